// File: doc/BRIEF.md
# SPI master controller with register file

This block is a byte-wide serial peripheral interface master that software controls through a small register file on an 8-bit bus. A write to the data register starts an eight-bit full-duplex exchange. The block drives the serial clock and the outgoing data line and samples the incoming data line. A read of the data register returns the byte that was shifted in. The serial clock's polarity and phase, the bit order and the clock rate are set through the control and baud registers. The slave-select pin is driven from a port data register and a direction register.

Three flags in the status register record a finished exchange, a data write made while a shift was still running, and a mode fault. A mode fault is a low level on the slave-select input while the block acts as the enabled master. Software clears a flag in two steps: it reads the status register and then reads the data register. Only the flags that the status read saw are cleared. Two interrupt lines carry the done flag and the fault flag, and the interrupt-enable bit gates both.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset, control, control2, baud, status and direction read 0, port data reads 0x08, sck is low, ss_n_out is high, ss_n_oe is low and both interrupt lines are low.
- R2: The bus reads back, at the same address, every value written to control (0x00), control2 (0x01), baud (0x04), port data (0x0D) and direction (0x10). Status (0x05) and received data (0x09) are read-only. In the control register, bit 7 is interrupt enable, bit 6 is enable, bit 4 is master, bit 3 is clock polarity, bit 2 is clock phase and bit 0 is LSB-first.
- R3: With prescaler field p in baud bits 6:4 and exponent e in baud bits 2:0, each sck half period lasts (p+1)*2^e clock cycles. The done flag is set exactly 16*(p+1)*2^e cycles after the data write. The smallest setting (p=0, e=0) gives a divider of 2.
- R4: A data write (0x09) starts an exchange only when enable and master are both set and no shift is running. A data read returns the last completed received byte. A data write with enable or master clear starts nothing.
- R5: When idle, sck rests at the polarity bit. With phase 0 each bit is sampled on the first edge of its clock period. With phase 1 it is sampled on the second edge. Each exchange makes 16 sck edges.
- R6: With bit 0 of control clear, the most significant bit goes out first and comes in first. With it set, the least significant bit goes first in both directions.
- R7: A data write made while a shift is running sets the collision flag (status bit 6). The running exchange continues unchanged.
- R8: The status flags (bit 7 done, bit 6 collision, bit 4 fault) clear only on a data read that follows a status read, and only the flags that read saw are cleared. A flag set in the same cycle as the clearing read stays set.
- R9: A low ss_n_in while enable and master are set and direction bit 3 is 0 sets the fault flag (status bit 4), clears control bits 6 and 4, aborts any shift and returns sck to its idle level. With direction bit 3 set, ss_n_in is ignored.
- R10: irq_done is high exactly when the done flag and the interrupt-enable bit are both set. irq_fault is high exactly when the fault flag and the interrupt-enable bit are both set.
- R11: ss_n_out follows port data bit 3 and ss_n_oe follows direction bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects on flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n_in | input | 1 | Slave-select input level used for fault detection |
| ss_n_out | output | 1 | Slave-select output level |
| ss_n_oe | output | 1 | Slave-select output enable |
| irq_fault | output | 1 | Mode-fault interrupt |
| irq_done | output | 1 | Transfer-done interrupt |

## Verification
The clearing data read and the completion of a new exchange can land on the same clock edge. The bench reads status while the done flag is set, starts a fresh exchange at the minimum divider, and counts cycles so that the data read is sampled on the very edge where the new exchange ends. The done flag must still read as set afterwards. A second collision happens when a data write coincides with a running shift. That case is judged by the collision flag and by the slave still capturing the first byte intact.

// File: rtl/spi_host_ctl.sv
module spi_host_ctl #(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int PW = 3,
  parameter int EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  input  logic          ss_n_in,
  output logic          ss_n_out,
  output logic          ss_n_oe,
  output logic          irq_fault,
  output logic          irq_done
);
  localparam int HW = PW + (1 << EW);
  localparam int EC = $clog2(2 * DW);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_CTRL2 = AW'(1);
  localparam logic [AW-1:0] A_BAUD  = AW'(4);
  localparam logic [AW-1:0] A_STAT  = AW'(5);
  localparam logic [AW-1:0] A_DATA  = AW'(9);
  localparam logic [AW-1:0] A_PORT  = AW'(13);
  localparam logic [AW-1:0] A_DIR   = AW'(16);

  logic [DW-1:0] ctrl, ctrl_nx, ctrl2, baud, port, dir;
  logic [DW-1:0] txsr, rxsr, rxbuf, rx_nx, rx_fin;
  logic          spif, wcol, modf, busy, sck_q;
  logic [2:0]    seen;
  logic [EC-1:0] edge_n;
  logic [HW-1:0] tmr, half;
  logic wr_ctl, wr_c2, wr_bd, wr_dt, wr_pt, wr_dr, rd_st, rd_dt;
  logic fault, run_ok, tick, smp, shf, last;

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) flip[i] = v[DW-1-i];
  endfunction

  assign wr_ctl = wr_en && addr == A_CTRL;
  assign wr_c2  = wr_en && addr == A_CTRL2;
  assign wr_bd  = wr_en && addr == A_BAUD;
  assign wr_dt  = wr_en && addr == A_DATA;
  assign wr_pt  = wr_en && addr == A_PORT;
  assign wr_dr  = wr_en && addr == A_DIR;
  assign rd_st  = rd_en && addr == A_STAT;
  assign rd_dt  = rd_en && addr == A_DATA;

  assign fault = ctrl[6] & ctrl[4] & ~ss_n_in & ~dir[3];

  always_comb begin
    ctrl_nx = wr_ctl ? wdata : ctrl;
    if (fault) begin
      ctrl_nx[6] = 1'b0;
      ctrl_nx[4] = 1'b0;
    end
  end

  assign run_ok = ctrl_nx[6] & ctrl_nx[4];
  assign half   = (HW'(baud[4 +: PW]) + HW'(1)) << baud[0 +: EW];
  assign tick   = busy & (tmr == half - HW'(1));
  assign smp    = (edge_n[0] == ctrl[2]);
  assign shf    = ~smp & ~(ctrl[2] & (edge_n == '0));
  assign last   = (edge_n == EC'(2 * DW - 1));
  assign rx_nx  = {rxsr[DW-2:0], miso};
  assign rx_fin = smp ? rx_nx : rxsr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      ctrl2  <= '0;
      baud   <= '0;
      port   <= DW'(8'h08);
      dir    <= '0;
      spif   <= 1'b0;
      wcol   <= 1'b0;
      modf   <= 1'b0;
      seen   <= '0;
      busy   <= 1'b0;
      sck_q  <= 1'b0;
      tmr    <= '0;
      edge_n <= '0;
      txsr   <= '0;
      rxsr   <= '0;
      rxbuf  <= '0;
    end else begin
      ctrl <= ctrl_nx;
      if (wr_c2) ctrl2 <= wdata;
      if (wr_bd) baud  <= wdata;
      if (wr_pt) port  <= wdata;
      if (wr_dr) dir   <= wdata;

      if (rd_st) seen <= {spif, wcol, modf};
      else if (rd_dt) seen <= '0;

      spif <= (spif & ~(rd_dt & seen[2])) | (tick & last & run_ok);
      wcol <= (wcol & ~(rd_dt & seen[1])) | (wr_dt & busy);
      modf <= (modf & ~(rd_dt & seen[0])) | fault;

      if (busy) begin
        if (!run_ok) begin
          busy <= 1'b0;
        end else if (tick) begin
          tmr    <= '0;
          sck_q  <= ~sck_q;
          edge_n <= edge_n + 1'b1;
          if (smp) rxsr <= rx_nx;
          if (shf) txsr <= {txsr[DW-2:0], 1'b0};
          if (last) begin
            busy  <= 1'b0;
            rxbuf <= ctrl[0] ? flip(rx_fin) : rx_fin;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end else if (wr_dt && run_ok) begin
        busy   <= 1'b1;
        tmr    <= '0;
        edge_n <= '0;
        sck_q  <= ctrl[3];
        txsr   <= ctrl[0] ? flip(wdata) : wdata;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl;
      A_CTRL2: rdata = ctrl2;
      A_BAUD:  rdata = baud;
      A_STAT:  rdata = {spif, wcol, 1'b0, modf, 4'b0000};
      A_DATA:  rdata = rxbuf;
      A_PORT:  rdata = port;
      A_DIR:   rdata = dir;
      default: rdata = '0;
    endcase
  end

  assign sck       = busy ? sck_q : ctrl[3];
  assign mosi      = txsr[DW-1];
  assign ss_n_out  = port[3];
  assign ss_n_oe   = dir[3];
  assign irq_done  = spif & ctrl[7];
  assign irq_fault = modf & ctrl[7];
endmodule

module spi_host_ctl_chk #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic          spif,
  input logic          wcol,
  input logic          modf,
  input logic          fault,
  input logic [DW-1:0] ctrl,
  input logic          irq_done,
  input logic          irq_fault
);
  AST_DONE_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(busy)); // R4
  AST_COLLISION_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(9) && busy) |=> wcol); // R7
  AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (modf && !busy && !ctrl[6] && !ctrl[4])); // R9
  AST_RUN_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ctrl[6] && ctrl[4])); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[7] |-> !(irq_done || irq_fault)); // R10
endmodule

bind spi_host_ctl spi_host_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy),
  .spif(spif), .wcol(wcol), .modf(modf), .fault(fault), .ctrl(ctrl),
  .irq_done(irq_done), .irq_fault(irq_fault)
);

// File: tb/spi_host_ctl_test.sv
module spi_host_ctl_test;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [4:0] addr = 5'd5;
  logic wr_en = 0, rd_en = 0, miso = 0, ss_n_in = 1;
  logic [7:0] wdata = 0;
  wire [7:0] rdata;
  wire sck, mosi, ss_n_out, ss_n_oe, irq_fault, irq_done;

  spi_host_ctl uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .ss_n_in(ss_n_in),
    .ss_n_out(ss_n_out), .ss_n_oe(ss_n_oe), .irq_fault(irq_fault), .irq_done(irq_done));

  int total = 0, bad = 0;
  bit chk_on = 0, fin = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // behavioural reference model
  logic [7:0] m_ctrl, m_dir, m_baud, nctrl;
  bit m_busy, m_spif, m_wcol, m_modf, flt, busy0;
  bit [2:0] m_seen, flg0, seen0;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_dir = 0; m_baud = 0; m_busy = 0;
      m_spif = 0; m_wcol = 0; m_modf = 0; m_seen = 0; m_cnt = 0;
    end else begin
      nctrl = (wr_en && addr == 0) ? wdata : m_ctrl;
      flt   = m_ctrl[6] && m_ctrl[4] && !ss_n_in && !m_dir[3];
      busy0 = m_busy;
      flg0  = {m_spif, m_wcol, m_modf};
      seen0 = m_seen;
      if (flt) begin nctrl[6] = 0; nctrl[4] = 0; end
      if (rd_en && addr == 9 && seen0 != 0) begin
        if (seen0[2]) m_spif = 0;
        if (seen0[1]) m_wcol = 0;
        if (seen0[0]) m_modf = 0;
        m_seen = 0;
      end
      if (rd_en && addr == 5) m_seen = flg0;
      if (m_busy) begin
        if (!(nctrl[6] && nctrl[4])) m_busy = 0;
        else begin
          m_cnt--;
          if (m_cnt == 0) begin m_busy = 0; m_spif = 1; end
        end
      end
      if (wr_en && addr == 9) begin
        if (busy0) m_wcol = 1;
        else if (nctrl[6] && nctrl[4]) begin
          m_busy = 1;
          m_cnt = 16 * ((((m_baud >> 4) & 7) + 1) << (m_baud & 7));
        end
      end
      if (flt) m_modf = 1;
      if (wr_en && addr == 4) m_baud = wdata;
      if (wr_en && addr == 16) m_dir = wdata;
      m_ctrl = nctrl;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && chk_on) begin
      chk(irq_done === (m_spif && m_ctrl[7]), "R10 irq_done vs model", irq_done, m_spif && m_ctrl[7]);
      chk(irq_fault === (m_modf && m_ctrl[7]), "R10 irq_fault vs model", irq_fault, m_modf && m_ctrl[7]);
      if (!m_busy) chk(sck === m_ctrl[3], "R5 idle sck level", sck, m_ctrl[3]);
      if (addr == 5)
        chk(rdata === {m_spif, m_wcol, 1'b0, m_modf, 4'b0}, "R8 status vs model",
            rdata, {m_spif, m_wcol, 1'b0, m_modf, 4'b0});
    end
  end

  // behavioural slave
  bit xon = 0, s_cpha = 0;
  int e = 0, b = 0;
  logic [7:0] sb = 0, cap = 0;
  always @(sck) if (xon) begin
    if ((e % 2) == s_cpha) begin
      cap = {cap[6:0], mosi};
      b++;
      if (b < 8) miso = sb[7-b];
    end
    e++;
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; addr = 5;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0; addr = 5;
  endtask

  task automatic arm_slave(input logic [7:0] c, input logic [7:0] sl);
    s_cpha = c[2]; sb = sl; e = 0; b = 0; cap = 0; miso = sl[7]; xon = 1;
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] bd, input logic [7:0] tb,
                      input logic [7:0] sl, input string tag);
    logic [7:0] d;
    int h;
    h = (((bd >> 4) & 7) + 1) << (bd & 7);
    wr(0, c); wr(4, bd);
    arm_slave(c, sl);
    wr(9, tb);
    repeat (16 * h - 1) @(negedge clk);
    #1 chk(rdata[7] == 0, {tag, " R3 not done one cycle early"}, rdata, 0);
    @(negedge clk);
    #1 chk(rdata[7] == 1, {tag, " R3 done at 16 half periods"}, rdata, 8'h80);
    xon = 0;
    chk(e == 16, {tag, " R5 sixteen sck edges"}, e, 16);
    if (c[7]) chk(irq_done == 1, {tag, " R10 irq_done raised"}, irq_done, 1);
    rd(5, d);
    rd(9, d);
    chk(d == (c[0] ? rev8(sl) : sl), {tag, " R4 R6 received byte"}, d, c[0] ? rev8(sl) : sl);
    chk(cap == (c[0] ? rev8(tb) : tb), {tag, " R5 R6 slave captured"}, cap, c[0] ? rev8(tb) : tb);
    rd(5, d);
    chk(d == 0, {tag, " R8 flags cleared"}, d, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!fin) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_on = 1;
    @(negedge clk);
    rd(0, d);  chk(d == 0, "R1 control reset", d, 0);
    rd(5, d);  chk(d == 0, "R1 status reset", d, 0);
    rd(13, d); chk(d == 8'h08, "R1 port reset", d, 8'h08);
    rd(16, d); chk(d == 0, "R1 direction reset", d, 0);
    chk(ss_n_out == 1 && ss_n_oe == 0, "R1 slave-select pins", {ss_n_out, ss_n_oe}, 2'b10);
    chk(sck == 0 && irq_done == 0 && irq_fault == 0, "R1 sck and irqs low",
        {sck, irq_done, irq_fault}, 0);

    wr(1, 8'h5A); rd(1, d); chk(d == 8'h5A, "R2 control2 readback", d, 8'h5A);
    wr(4, 8'h73); rd(4, d); chk(d == 8'h73, "R2 baud readback", d, 8'h73);
    wr(0, 8'h2D); rd(0, d); chk(d == 8'h2D, "R2 control readback", d, 8'h2D);
    wr(0, 8'h00);
    wr(16, 8'h08); chk(ss_n_oe == 1, "R11 oe follows direction bit3", ss_n_oe, 1);
    rd(16, d); chk(d == 8'h08, "R2 direction readback", d, 8'h08);
    wr(13, 8'h00); chk(ss_n_out == 0, "R11 ss asserted", ss_n_out, 0);
    wr(13, 8'h08); chk(ss_n_out == 1, "R11 ss deasserted", ss_n_out, 1);

    wr(0, 8'h10); wr(4, 8'h00); wr(9, 8'hAA);
    repeat (40) @(negedge clk);
    rd(5, d); chk(d == 0, "R4 no start without enable", d, 0);

    xfer(8'h50, 8'h00, 8'hA5, 8'h3C, "mode0 msb");
    xfer(8'h5C, 8'h21, 8'h96, 8'hC3, "mode3 msb");
    xfer(8'h55, 8'h10, 8'h1E, 8'h81, "mode1 lsb");
    xfer(8'h59, 8'h03, 8'h6B, 8'h4D, "mode2 lsb");
    xfer(8'hD0, 8'h77, 8'hC9, 8'h5E, "max divider irq");

    // R7 collision
    wr(0, 8'h50); wr(4, 8'h00);
    arm_slave(8'h50, 8'h99);
    wr(9, 8'h33);
    wr(9, 8'hFF);
    repeat (16) @(negedge clk);
    xon = 0;
    rd(5, d); chk(d == 8'hC0, "R7 collision and done flags", d, 8'hC0);
    rd(9, d); chk(d == 8'h99, "R7 first exchange intact rx", d, 8'h99);
    chk(cap == 8'h33, "R7 first exchange intact tx", cap, 8'h33);
    rd(5, d); chk(d == 0, "R8 both seen flags cleared", d, 0);

    // R8 data read without status read does not clear
    wr(9, 8'h11);
    repeat (16) @(negedge clk);
    rd(9, d);
    rd(5, d); chk(d == 8'h80, "R8 no clear without status read", d, 8'h80);
    // same-cycle set and clear
    wr(9, 8'h22);
    repeat (15) @(negedge clk);
    rd(9, d);
    rd(5, d); chk(d == 8'h80, "R8 set wins over same-cycle clear", d, 8'h80);
    rd(9, d);
    rd(5, d); chk(d == 0, "R8 cleared afterwards", d, 0);

    // R9 ignored when pin is an output
    wr(16, 8'h08); wr(0, 8'h50);
    ss_n_in = 0;
    repeat (3) @(negedge clk);
    ss_n_in = 1;
    rd(0, d); chk(d == 8'h50, "R9 ss_n_in ignored as output", d, 8'h50);
    rd(5, d); chk(d == 0, "R9 no fault flag as output", d, 0);

    // R9 mode fault mid-shift
    wr(16, 8'h00); wr(0, 8'hD0); wr(4, 8'h03);
    wr(9, 8'h5A);
    repeat (20) @(negedge clk);
    ss_n_in = 0;
    @(negedge clk);
    ss_n_in = 1;
    #2;
    chk(irq_fault == 1, "R9 R10 fault interrupt", irq_fault, 1);
    chk(sck == 0, "R9 sck back to idle", sck, 0);
    @(negedge clk);
    rd(0, d); chk(d == 8'h80, "R9 enable and master cleared", d, 8'h80);
    rd(5, d); chk(d == 8'h10, "R9 fault flag only", d, 8'h10);
    rd(9, d);
    rd(5, d); chk(d == 0, "R8 fault flag cleared", d, 0);
    chk(irq_fault == 0, "R10 fault interrupt drops", irq_fault, 0);

    repeat (4) @(negedge clk);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule